// File: doc/BRIEF.md
# Fifth-Order Decimating Bitstream Filter

This block turns the one-bit stream of a delta-sigma modulator into signed 24-bit conversion words. It uses a fifth-order cascaded integrator-comb structure that decimates by 64. Its response is five chained length-64 moving averages. The notches fall at the output word rate and at its integer multiples.

The block makes its own modulator sample strobe by dividing the system clock by 6. That strobe also goes out, so the modulator can step in lock with the filter. One word is produced every 64 strobes, which is one word per 384 system clocks. Each word is narrowed to 24 bits, and codes outside the 24-bit two's-complement range are clamped.

A synchronous restart clears all filter history and starts the settling period again. A small state machine hides words until the filter has settled. It has two states:
- `ST_FILL` counts the first decimated words after a reset or restart.
- `ST_LIVE` releases every word.

Transition `FILL_TO_LIVE` happens on the fifth decimated word, and that word is the first one released. Transition `ANY_TO_FILL` happens on reset or restart.

Top module: `sinc5_decimator`

## Requirements
- R1: Once settled, a periodic input whose period divides 64 and whose mean is m (in units of ±1) gives the word m·2^23. A stream that is 3/4 ones gives 400000 hex, and a stream that is 1/4 ones gives C00000 hex.
- R2: `mod_tick` is high for exactly one system clock in every 6. After a restart, it first goes high in the 6th cycle.
- R3: `res_valid` is a one-cycle strobe. It always follows a cycle in which `mod_tick` was high. Once settled, strobes are exactly 384 cycles apart.
- R4: After the clock edge that samples restart, the first `res_valid` appears exactly 1920 cycles later. No strobe appears before that.
- R5: A `mod_bit` of 1 counts as +1 and a 0 counts as −1, so an alternating 1,0 stream gives the word 000000.
- R6: Results are clamped to the 24-bit range. A stream of all ones gives 7FFFFF hex, and a stream of all zeros gives 800000 hex.
- R7: A restart in the middle of a conversion discards all earlier history. The first released word then depends only on samples taken after the restart.
- R8: While `rst_n` is low, `res_valid`, `mod_tick` and `result` are all 0.
- R9: `result` changes only together with a `res_valid` strobe. A restart leaves the last released word on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of the filter history and the settling count |
| mod_bit | input | 1 | Modulator output bit, sampled on cycles where `mod_tick` is high |
| mod_tick | output | 1 | Modulator sample strobe, one cycle in 6 |
| res_valid | output | 1 | One-cycle strobe marking a settled word |
| result | output | 24 | Signed two's-complement conversion word |

## Verification
Every scenario starts with a restart, and the bench counts falling edges from the edge that sampled it. `mod_tick` is due in cycle 5 of each 6-cycle group. The first settled word is due exactly 1920 cycles after the restart, and each later word follows 384 cycles after the one before. At every falling edge the bench checks that no strobe comes early. It compares the word only on the strobe cycle that the count predicts. It also checks that `result` still holds the previous word in cycle 1919.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_LIVE = 1'b1
    } settle_state_e;
endpackage

// File: rtl/sinc_tick_div.sv
module sinc_tick_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
    parameter int ORDER = 5,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] acc_out
);
    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] acc_d [ORDER];
    logic signed [ACC_W-1:0] step;

    // 1 -> +1, 0 -> -1
    assign step = {{(ACC_W-1){~bit_in}}, 1'b1};

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign acc_d[k] = acc_q[k] + step;
        end else begin : g_next
            assign acc_d[k] = acc_q[k] + acc_d[k-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc_q[k] <= '0;
            else if (clr)
                acc_q[k] <= '0;
            else if (en)
                acc_q[k] <= acc_d[k];
        end
    end

    assign acc_out = acc_d[ORDER-1];
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
    parameter int ORDER = 5,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    logic signed [ACC_W-1:0] dly_q [ORDER];
    logic signed [ACC_W-1:0] sig   [ORDER+1];

    assign sig[0] = din;

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        assign sig[k+1] = sig[k] - dly_q[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dly_q[k] <= '0;
            else if (clr)
                dly_q[k] <= '0;
            else if (en)
                dly_q[k] <= sig[k];
        end
    end

    assign dout = sig[ORDER];
endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator #(
    parameter int ORDER  = 5,
    parameter int DEC    = 64,
    parameter int DIV    = 6,
    parameter int SETTLE = 5,
    parameter int OUT_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             mod_bit,
    output logic             mod_tick,
    output logic             res_valid,
    output logic [OUT_W-1:0] result
);
    import sinc_pkg::*;

    localparam int LOG2DEC = $clog2(DEC);
    localparam int GROWTH  = ORDER * LOG2DEC;
    localparam int ACC_W   = GROWTH + 2;
    localparam int SHIFT   = GROWTH - (OUT_W - 1);
    localparam int SCW     = $clog2(SETTLE + 1);
    localparam int HI_CODE = 2**(OUT_W-1) - 1;
    localparam int LO_CODE = -(2**(OUT_W-1));

    logic                    tick;
    logic [LOG2DEC-1:0]      phase_q;
    logic                    dec_strobe;
    logic signed [ACC_W-1:0] integ_out;
    logic signed [ACC_W-1:0] comb_out;
    logic signed [ACC_W-1:0] scaled;
    logic [OUT_W-1:0]        clamped;
    settle_state_e           state_q, state_d;
    logic [SCW-1:0]          settle_q;
    logic                    last_fill;
    logic                    release_word;

    sinc_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick)
    );

    sinc_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .en      (tick),
        .bit_in  (mod_bit),
        .acc_out (integ_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (tick)
            phase_q <= phase_q + 1'b1;
    end

    assign dec_strobe = tick && (phase_q == LOG2DEC'(DEC - 1));

    sinc_comb_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (dec_strobe),
        .din   (integ_out),
        .dout  (comb_out)
    );

    // Narrow to the output width and clamp at the code limits
    assign scaled = comb_out >>> SHIFT;

    always_comb begin
        if (scaled > signed'(ACC_W'(HI_CODE)))
            clamped = OUT_W'(HI_CODE);
        else if (scaled < signed'(ACC_W'(LO_CODE)))
            clamped = OUT_W'(LO_CODE);
        else
            clamped = scaled[OUT_W-1:0];
    end

    // Settling state machine
    assign last_fill = (settle_q == SCW'(SETTLE - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (dec_strobe && last_fill) state_d = ST_LIVE; // FILL_TO_LIVE
            ST_LIVE: state_d = ST_LIVE;
        endcase
        if (restart) state_d = ST_FILL;                          // ANY_TO_FILL
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_FILL;
        else
            state_q <= state_d;
    end

    assign release_word = dec_strobe && ((state_q == ST_LIVE) || last_fill);

    // Outputs and settle count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q  <= '0;
            res_valid <= 1'b0;
            result    <= '0;
        end else if (restart) begin
            settle_q  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= release_word;
            if (release_word)
                result <= clamped;
            if (dec_strobe && (state_q == ST_FILL) && !last_fill)
                settle_q <= settle_q + 1'b1;
        end
    end

    assign mod_tick = tick;
endmodule

// File: rtl/sinc5_decimator_chk.sv
module sinc5_decimator_chk #(
    parameter int DEC    = 64,
    parameter int DIV    = 6,
    parameter int SETTLE = 5,
    parameter int OUT_W  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             mod_tick,
    input logic             res_valid,
    input logic [OUT_W-1:0] result
);
    localparam int SETTLE_CYC = SETTLE * DEC * DIV;
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int GW = $clog2(DIV + 1);

    logic [SW-1:0] since_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            gap_q   <= '0;
        end else if (restart) begin
            since_q <= '0;
            gap_q   <= '0;
        end else begin
            if (since_q != SW'(SETTLE_CYC))
                since_q <= since_q + 1'b1;
            if (mod_tick)
                gap_q <= '0;
            else if (gap_q != GW'(DIV))
                gap_q <= gap_q + 1'b1;
        end
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        mod_tick |-> (gap_q == GW'(DIV - 1)));                              // R2
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_tick |=> !mod_tick);                                            // R2
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(mod_tick));                                     // R3
    AST_SETTLE_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (since_q == SW'(SETTLE_CYC)));                        // R4
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !res_valid);                                            // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(result));                                    // R9
endmodule

bind sinc5_decimator sinc5_decimator_chk #(
    .DEC(DEC), .DIV(DIV), .SETTLE(SETTLE), .OUT_W(OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .mod_tick  (mod_tick),
    .res_valid (res_valid),
    .result    (result)
);

// File: tb/tb_sinc5_decimator.sv
`timescale 1ns/1ps
module tb_sinc5_decimator;
    localparam int SETTLE_CYC = 1920;
    localparam int WORD_CYC   = 384;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        mod_bit = 1'b0;
    logic        mod_tick;
    logic        res_valid;
    logic [23:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int idx = 0;

    always #2 clk = ~clk;

    sinc5_decimator dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .mod_bit   (mod_bit),
        .mod_tick  (mod_tick),
        .res_valid (res_valid),
        .result    (result)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kinds: 0 all ones, 1 all zeros, 2 alternating, 3 three-quarter ones, 4 quarter ones
    function automatic logic pat(input int kind, input int i);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return (i % 2 == 0);
            3: return (i % 4 != 0);
            default: return (i % 4 == 0);
        endcase
    endfunction

    task automatic do_restart();
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        idx = 0;
    endtask

    // One negedge step: drive the next sample when the tick is up
    task automatic step(input int kind);
        @(negedge clk);
        if (mod_tick) begin
            mod_bit = pat(kind, idx);
            idx++;
        end
    endtask

    task automatic run_pattern(input int kind, input logic [23:0] exp, input string req);
        logic [23:0] held;
        int first;
        int last;
        int early;
        held  = result;
        first = -1;
        last  = -1;
        early = 0;
        do_restart();
        for (int n = 1; n <= SETTLE_CYC + 2 * WORD_CYC; n++) begin
            step(kind);
            if (n == SETTLE_CYC - 1)
                check(result == held, "R9", "result held while settling", result, held);
            if (res_valid) begin
                if (n < SETTLE_CYC) early++;
                if (first < 0) begin
                    first = n;
                    check(n == SETTLE_CYC, "R4", "first strobe cycle", n, SETTLE_CYC);
                end else begin
                    check(n - last == WORD_CYC, "R3", "strobe spacing", n - last, WORD_CYC);
                end
                check(result == exp, req, "settled word", result, exp);
                last = n;
            end
        end
        check(early == 0, "R4", "strobes before settling", early, 0);
    endtask

    task automatic test_reset();
        check(res_valid == 1'b0, "R8", "valid in reset", res_valid, 0);
        check(mod_tick == 1'b0, "R8", "tick in reset", mod_tick, 0);
        check(result == 24'h0, "R8", "result in reset", result, 0);
    endtask

    task automatic test_tick();
        int last;
        int highs;
        last  = -1;
        highs = 0;
        do_restart();
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            if (mod_tick) begin
                highs++;
                if (last < 0)
                    check(n == 5, "R2", "first tick cycle", n, 5);
                else
                    check(n - last == 6, "R2", "tick period", n - last, 6);
                last = n;
            end
        end
        check(highs == 10, "R2", "ticks in 60 cycles", highs, 10);
    endtask

    task automatic test_mid_restart();
        // partway through a conversion on another stream, then restart
        for (int n = 0; n < 1000; n++) step(0);
        run_pattern(3, 24'h400000, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_tick();
        run_pattern(0, 24'h7FFFFF, "R6");
        run_pattern(1, 24'h800000, "R6");
        run_pattern(2, 24'h000000, "R5");
        run_pattern(3, 24'h400000, "R1");
        run_pattern(4, 24'hC00000, "R1");
        test_mid_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule